// File: doc/BRIEF.md
# Configurable Macrocell Register Stage

This block is one programmable register cell of a logic array. It takes one logic value, a set of candidate clocks, six control terms, a global three-state pin and a power-on reset. It drives a pad as a value plus an enable, and it returns two feedback values to the routing: one taken inside the cell and one taken at the pin. Static configuration inputs choose whether the storage element loads (D) or toggles (T), which clock and which edge it follows, which control terms may force it to 0 or 1, where the pad enable comes from, and whether the output bypasses the register.

The cell runs on one fast sampling clock, `sys_clk`. The candidate clocks are handled as data: the cell keeps their previous samples and detects the chosen edge. Clock 0 always comes from its external input. Clocks 1 and above can be swapped for a clock made by internal logic (`int_clk`). Preset and reset act as levels, are sampled by `sys_clk`, and override any clock edge.

Top module: `mc_macrocell`

## Requirements
- R1: While `por_n` is low the register holds 0, and with bypass off `pad_out` and `fb_cell` read 0.
- R2: `cfg_clk_sel` picks one of the clocks. With `cfg_clk_fall`=0 the cell acts on a 0-to-1 change of that clock, and with 1 on a 1-to-0 change. Activity on the clocks that are not selected has no effect. The change is seen between two `sys_clk` samples, and the register updates on the `sys_clk` edge at which the new clock level is first sampled.
- R3: With `cfg_toggle`=0 a selected edge loads `d_in` into the register.
- R4: With `cfg_toggle`=1 a selected edge inverts the register when `d_in`=1 and leaves it unchanged when `d_in`=0.
- R5: With `cfg_clk_int`=1, clock indices 1 and up take `int_clk` in place of their external input. Clock index 0 always uses `clk_in[0]`.
- R6: When `cfg_rst_en`=1 and `ct[0]`=1, the register goes to 0. When `cfg_set_en`=1 and `ct[1]`=1, it goes to 1. If both are requested, reset wins. Either request overrides a clock edge in the same cycle. A control term whose enable is 0 is ignored.
- R7: If no init request is active and no selected edge occurs, the register keeps its value.
- R8: `cfg_oe_mode` values 0 to 3 take the pad enable from `ct[2]` to `ct[5]`, value 4 forces the pad on, and values 5 to 7 force it off.
- R9: When `cfg_gts_en`=1 and `gts_n`=0, `pad_oe` is 0 whatever the other settings. When `cfg_gts_en`=0, `gts_n` has no effect.
- R10: `fb_cell` always carries the cell output value. `fb_pin` carries `pad_out` when `pad_oe`=1 and `pad_in` when `pad_oe`=0.
- R11: With `cfg_bypass`=1, `pad_out` and `fb_cell` equal `d_in` combinationally, in place of the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Sampling clock for the whole cell |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| clk_in | input | CLK_N | Candidate clocks from external pins |
| int_clk | input | 1 | Clock from internal logic, for indices 1 and up |
| d_in | input | 1 | Logic input from the product-term array |
| ct | input | CT_N | Control terms: 0 reset, 1 preset, others pad enable |
| gts_n | input | 1 | Global three-state pin, active low |
| pad_in | input | 1 | Value present at the pad |
| cfg_toggle | input | 1 | 1 selects T operation, 0 selects D |
| cfg_clk_sel | input | clog2(CLK_N) | Clock index |
| cfg_clk_fall | input | 1 | 1 selects the falling edge |
| cfg_clk_int | input | 1 | Replace clocks 1 and up with int_clk |
| cfg_rst_en | input | 1 | Allow ct[0] to reset the register |
| cfg_set_en | input | 1 | Allow ct[1] to preset the register |
| cfg_oe_mode | input | clog2(CT_N-2)+1 | Pad enable source |
| cfg_gts_en | input | 1 | Let gts_n force the pad off |
| cfg_bypass | input | 1 | Output d_in in place of the register |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_cell | output | 1 | Feedback taken before the pad driver |
| fb_pin | output | 1 | Feedback taken at the pin |

## Verification
The bench builds the cell with its defaults, CLK_N=4 and CT_N=6. This gives the four enable control terms behind `cfg_oe_mode` 0 to 3 and the forced codes 4 to 7. It also puts three clock indices within reach of the internal-clock swap, and leaves index 0 as the one that always stays external. Each configuration phase drives random clock, data, control-term and pin activity against a behavioural model. This covers both edge polarities, toggling on held data, simultaneous preset and reset, and the global three-state override with its enable on and off.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // next register value for a clock event
  function automatic logic mc_next(input logic q, input logic d, input logic toggle);
    return toggle ? (q ^ d) : d;
  endfunction

  // edge detect between an old and a new clock sample
  function automatic logic mc_edge(input logic old_s, input logic new_s, input logic fall);
    return fall ? (old_s & ~new_s) : (new_s & ~old_s);
  endfunction

endpackage

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
  parameter int CLK_N = 4,
  localparam int SELW = (CLK_N > 1) ? $clog2(CLK_N) : 1
) (
  input  logic             sys_clk,
  input  logic             por_n,
  input  logic [CLK_N-1:0] clk_in,
  input  logic             int_clk,
  input  logic [SELW-1:0]  cfg_sel,
  input  logic             cfg_fall,
  input  logic             cfg_int,
  output logic             tick
);
  logic [CLK_N-1:0] eff_clk;
  logic [CLK_N-1:0] prev_clk;
  logic             cur_s;
  logic             old_s;

  // index 0 is always external; higher indices may take the internal clock
  for (genvar i = 0; i < CLK_N; i++) begin : g_src
    if (i == 0) begin : g_ext
      assign eff_clk[i] = clk_in[i];
    end else begin : g_mux
      assign eff_clk[i] = cfg_int ? int_clk : clk_in[i];
    end
  end

  always_ff @(posedge sys_clk or negedge por_n) begin
    if (!por_n) prev_clk <= '0;
    else        prev_clk <= eff_clk;
  end

  assign cur_s = eff_clk[cfg_sel];
  assign old_s = prev_clk[cfg_sel];
  assign tick  = mc_pkg::mc_edge(old_s, cur_s, cfg_fall);

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic sys_clk,
  input  logic por_n,
  input  logic d,
  input  logic toggle,
  input  logic tick,
  input  logic ct_rst,
  input  logic ct_set,
  input  logic rst_en,
  input  logic set_en,
  output logic q
);
  logic rst_act;
  logic set_act;

  assign rst_act = rst_en & ct_rst;
  assign set_act = set_en & ct_set;

  always_ff @(posedge sys_clk or negedge por_n) begin
    if (!por_n)       q <= 1'b0;
    else if (rst_act) q <= 1'b0;
    else if (set_act) q <= 1'b1;
    else if (tick)    q <= mc_pkg::mc_next(q, d, toggle);
  end

  AST_RESET_WINS: assert property (@(posedge sys_clk) disable iff (!por_n)
    rst_act |=> !q); // R6
  AST_PRESET_ONE: assert property (@(posedge sys_clk) disable iff (!por_n)
    (set_act && !rst_act) |=> q); // R6
  AST_HOLD_STATE: assert property (@(posedge sys_clk) disable iff (!por_n)
    (!rst_act && !set_act && !tick) |=> $stable(q)); // R7
  AST_D_LOAD: assert property (@(posedge sys_clk) disable iff (!por_n)
    (tick && !toggle && !rst_act && !set_act) |=> (q == $past(d))); // R3
  AST_T_FLIP: assert property (@(posedge sys_clk) disable iff (!por_n)
    (tick && toggle && !rst_act && !set_act) |=> (q == ($past(q) ^ $past(d)))); // R4

endmodule

// File: rtl/mc_pad.sv
module mc_pad #(
  parameter int OE_N = 4,
  localparam int OEW = $clog2(OE_N) + 1
) (
  input  logic            q,
  input  logic            d,
  input  logic            bypass,
  input  logic [OEW-1:0]  oe_mode,
  input  logic [OE_N-1:0] oe_ct,
  input  logic            gts_en,
  input  logic            gts_n,
  input  logic            pad_in,
  output logic            pad_out,
  output logic            pad_oe,
  output logic            fb_cell,
  output logic            fb_pin
);
  logic cell_val;
  logic oe_pick;
  logic gts_kill;

  // top bit clear: control term; top bit set: low bits zero forces on
  always_comb begin
    if (!oe_mode[OEW-1]) oe_pick = oe_ct[oe_mode[OEW-2:0]];
    else                 oe_pick = (oe_mode[OEW-2:0] == '0);
  end

  assign gts_kill = gts_en & ~gts_n;
  assign cell_val = bypass ? d : q;
  assign pad_out  = cell_val;
  assign fb_cell  = cell_val;
  assign pad_oe   = oe_pick & ~gts_kill;
  assign fb_pin   = pad_oe ? cell_val : pad_in;

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
  parameter int CLK_N = 4,
  parameter int CT_N  = 6,
  localparam int SELW = (CLK_N > 1) ? $clog2(CLK_N) : 1,
  localparam int OE_N = CT_N - 2,
  localparam int OEW  = $clog2(OE_N) + 1
) (
  input  logic             sys_clk,
  input  logic             por_n,
  input  logic [CLK_N-1:0] clk_in,
  input  logic             int_clk,
  input  logic             d_in,
  input  logic [CT_N-1:0]  ct,
  input  logic             gts_n,
  input  logic             pad_in,
  input  logic             cfg_toggle,
  input  logic [SELW-1:0]  cfg_clk_sel,
  input  logic             cfg_clk_fall,
  input  logic             cfg_clk_int,
  input  logic             cfg_rst_en,
  input  logic             cfg_set_en,
  input  logic [OEW-1:0]   cfg_oe_mode,
  input  logic             cfg_gts_en,
  input  logic             cfg_bypass,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             fb_cell,
  output logic             fb_pin
);
  logic clk_tick;
  logic reg_q;

  mc_clk_pick #(.CLK_N(CLK_N)) u_clk (
    .sys_clk (sys_clk),
    .por_n   (por_n),
    .clk_in  (clk_in),
    .int_clk (int_clk),
    .cfg_sel (cfg_clk_sel),
    .cfg_fall(cfg_clk_fall),
    .cfg_int (cfg_clk_int),
    .tick    (clk_tick)
  );

  mc_store u_store (
    .sys_clk(sys_clk),
    .por_n  (por_n),
    .d      (d_in),
    .toggle (cfg_toggle),
    .tick   (clk_tick),
    .ct_rst (ct[0]),
    .ct_set (ct[1]),
    .rst_en (cfg_rst_en),
    .set_en (cfg_set_en),
    .q      (reg_q)
  );

  mc_pad #(.OE_N(OE_N)) u_pad (
    .q      (reg_q),
    .d      (d_in),
    .bypass (cfg_bypass),
    .oe_mode(cfg_oe_mode),
    .oe_ct  (ct[CT_N-1:2]),
    .gts_en (cfg_gts_en),
    .gts_n  (gts_n),
    .pad_in (pad_in),
    .pad_out(pad_out),
    .pad_oe (pad_oe),
    .fb_cell(fb_cell),
    .fb_pin (fb_pin)
  );

  AST_GTS_FORCE: assert property (@(posedge sys_clk) disable iff (!por_n)
    (cfg_gts_en && !gts_n) |-> !pad_oe); // R9
  AST_PIN_FB: assert property (@(posedge sys_clk) disable iff (!por_n)
    !pad_oe |-> (fb_pin == pad_in)); // R10
  AST_BYPASS: assert property (@(posedge sys_clk) disable iff (!por_n)
    cfg_bypass |-> (pad_out == d_in && fb_cell == d_in)); // R11
  AST_REG_OUT: assert property (@(posedge sys_clk) disable iff (!por_n)
    !cfg_bypass |-> (pad_out == reg_q)); // R10

endmodule

// File: tb/mc_macrocell_tb.sv
module mc_macrocell_tb;
  logic       sys_clk = 1'b0;
  logic       por_n = 1'b0;
  logic [3:0] clk_in = '0;
  logic       int_clk = 1'b0;
  logic       d_in = 1'b0;
  logic [5:0] ct = '0;
  logic       gts_n = 1'b1;
  logic       pad_in = 1'b0;
  logic       cfg_toggle = 1'b0;
  logic [1:0] cfg_clk_sel = '0;
  logic       cfg_clk_fall = 1'b0;
  logic       cfg_clk_int = 1'b0;
  logic       cfg_rst_en = 1'b0;
  logic       cfg_set_en = 1'b0;
  logic [2:0] cfg_oe_mode = 3'd4;
  logic       cfg_gts_en = 1'b0;
  logic       cfg_bypass = 1'b0;
  logic       pad_out, pad_oe, fb_cell, fb_pin;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string phase = "R1";
  int    init_rate = 8;

  // behavioural reference state
  bit m_q = 0;
  bit m_prev [4] = '{0, 0, 0, 0};

  always #5 sys_clk = ~sys_clk;

  mc_macrocell u_dut (
    .sys_clk(sys_clk), .por_n(por_n), .clk_in(clk_in), .int_clk(int_clk),
    .d_in(d_in), .ct(ct), .gts_n(gts_n), .pad_in(pad_in),
    .cfg_toggle(cfg_toggle), .cfg_clk_sel(cfg_clk_sel), .cfg_clk_fall(cfg_clk_fall),
    .cfg_clk_int(cfg_clk_int), .cfg_rst_en(cfg_rst_en), .cfg_set_en(cfg_set_en),
    .cfg_oe_mode(cfg_oe_mode), .cfg_gts_en(cfg_gts_en), .cfg_bypass(cfg_bypass),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_cell(fb_cell), .fb_pin(fb_pin)
  );

  always @(posedge sys_clk) begin
    bit now [4];
    bit hit;
    for (int i = 0; i < 4; i++) now[i] = (i > 0 && cfg_clk_int) ? int_clk : clk_in[i];
    if (!por_n) begin
      m_q = 0;
      for (int i = 0; i < 4; i++) m_prev[i] = 0;
    end else begin
      if (cfg_clk_fall) hit = (m_prev[cfg_clk_sel] == 1) && (now[cfg_clk_sel] == 0);
      else              hit = (m_prev[cfg_clk_sel] == 0) && (now[cfg_clk_sel] == 1);
      if (cfg_rst_en && ct[0])      m_q = 0;
      else if (cfg_set_en && ct[1]) m_q = 1;
      else if (hit) begin
        if (cfg_toggle) begin
          if (d_in) m_q = !m_q;
        end else m_q = d_in;
      end
      for (int i = 0; i < 4; i++) m_prev[i] = now[i];
    end
  end

  task automatic compare();
    bit e_val, e_oe, e_fb;
    e_val = cfg_bypass ? d_in : m_q;
    if (cfg_oe_mode < 3'd4) e_oe = ct[2 + cfg_oe_mode];
    else                    e_oe = (cfg_oe_mode == 3'd4);
    if (cfg_gts_en && !gts_n) e_oe = 0;
    e_fb = e_oe ? e_val : pad_in;
    n_cmp++;
    if (pad_out !== e_val || fb_cell !== e_val || pad_oe !== e_oe || fb_pin !== e_fb) begin
      n_bad++;
      $display("FAIL %s t=%0t out/cell/oe/pin actual=%b%b%b%b expected=%b%b%b%b",
               phase, $time, pad_out, fb_cell, pad_oe, fb_pin, e_val, e_val, e_oe, e_fb);
    end
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge sys_clk);
      compare();
      clk_in  = 4'($urandom_range(0, 15));
      int_clk = 1'($urandom_range(0, 1));
      d_in    = 1'($urandom_range(0, 1));
      pad_in  = 1'($urandom_range(0, 1));
      gts_n   = 1'($urandom_range(0, 1));
      ct[5:2] = 4'($urandom_range(0, 15));
      ct[0]   = ($urandom_range(0, init_rate - 1) == 0);
      ct[1]   = ($urandom_range(0, init_rate - 1) == 0);
    end
  endtask

  task automatic setup(bit tg, int sel, bit fall, bit ci, bit re, bit se,
                       int oem, bit ge, bit byp);
    @(negedge sys_clk);
    cfg_toggle = tg; cfg_clk_sel = 2'(sel); cfg_clk_fall = fall; cfg_clk_int = ci;
    cfg_rst_en = re; cfg_set_en = se; cfg_oe_mode = 3'(oem); cfg_gts_en = ge;
    cfg_bypass = byp;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge sys_clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset held with activity on every input
    phase = "R1";
    run(20);
    @(negedge sys_clk); por_n = 1'b1;
    // R3: D load on rising edge of clock 0
    phase = "R3"; setup(0, 0, 0, 0, 0, 0, 4, 0, 0); run(300);
    // R2: other clocks and falling edge
    phase = "R2"; setup(0, 2, 1, 0, 0, 0, 4, 0, 0); run(300);
    phase = "R2"; setup(0, 3, 0, 0, 0, 0, 4, 0, 0); run(300);
    // R4: toggle operation
    phase = "R4"; setup(1, 1, 0, 0, 0, 0, 4, 0, 0); run(300);
    phase = "R4"; setup(1, 0, 1, 0, 0, 0, 4, 0, 0); run(300);
    // R5: internal clock replaces index 3, never index 0
    phase = "R5"; setup(0, 3, 0, 1, 0, 0, 4, 0, 0); run(300);
    phase = "R5"; setup(0, 0, 0, 1, 0, 0, 4, 0, 0); run(300);
    // R6: frequent preset/reset, both enabled, reset priority
    init_rate = 2;
    phase = "R6"; setup(1, 1, 0, 0, 1, 1, 4, 0, 0); run(400);
    phase = "R6"; setup(0, 2, 0, 0, 0, 1, 4, 0, 0); run(300);
    // R7: init terms active but disabled, so only edges matter
    phase = "R7"; setup(0, 1, 1, 0, 0, 0, 4, 0, 0); run(300);
    init_rate = 8;
    // R8: every pad enable code
    for (int m = 0; m < 8; m++) begin
      phase = "R8"; setup(0, 0, 0, 0, 1, 1, m, 0, 0); run(120);
    end
    // R9: global three-state enabled on several sources
    phase = "R9"; setup(0, 0, 0, 0, 0, 0, 4, 1, 0); run(300);
    phase = "R9"; setup(1, 2, 0, 0, 1, 1, 1, 1, 0); run(300);
    // R10: pin feedback with the driver off and on
    phase = "R10"; setup(0, 1, 0, 0, 0, 0, 6, 0, 0); run(200);
    phase = "R10"; setup(0, 1, 0, 0, 0, 0, 3, 0, 0); run(200);
    // R11: combinational bypass
    phase = "R11"; setup(0, 0, 0, 0, 1, 1, 4, 0, 1); run(300);
    // R1: reset again mid-run
    phase = "R1"; setup(1, 0, 0, 0, 1, 1, 4, 0, 0);
    por_n = 1'b0; run(20);
    @(negedge sys_clk); compare();
    done = 1;
    summary();
    $finish;
  end

endmodule